// File: doc/BRIEF.md
# Multi-Channel Word Transfer Controller

This block moves single 16-bit words between peripherals and memory on behalf of up to sixteen channels without processor help. A channel holds no transfer registers inside the block. Its state is a pair of consecutive words in low memory. The first word of the pair is the next transfer address. Its top bit gives the direction of the channel. The second word is the last address to be transferred. Software sets up a pair, and the device then raises its request line once for each word it wants moved.

A request starts a fixed sequence of four memory cycles. The block reads the pair, reads or writes the data word, and writes the advanced address back. When the data word that was just moved sits at the last address, the channel gets a completion pulse. The channel then stops serving requests until software writes a fresh start word. The block sees that write through a snoop of processor memory writes.

The controller has five states:
- ST_IDLE: arbitration.
- ST_RD_START: read the start word.
- ST_RD_END: latch the start word and read the end word.
- ST_MOVE: latch the end word and move the data word.
- ST_WRBACK: write back the start word, acknowledge, and signal completion when due.

The transitions are:
- IDLE→RD_START when an eligible request exists. IDLE stays put otherwise.
- RD_START→RD_END, RD_END→MOVE and MOVE→WRBACK, each unconditionally.
- WRBACK→IDLE, unconditionally.

Top module: `dmc_engine`

## Requirements
- R1: After reset no channel is acknowledged, no channel is completed, no strobe is active, and neither mem_rd nor mem_wr is asserted. mem_rd and mem_wr are never asserted together.
- R2: The pointer pair of channel k (port bit k, k = 0..15) is at word addresses 16+2k (start word) and 17+2k (end word).
- R3: A start word with bit 15 = 1 makes an input channel. The word on dev_in_data slice k (bits 16k+15..16k) is written to memory at start[14:0].
- R4: A start word with bit 15 = 0 makes an output channel. The memory word at start[14:0] appears on dev_out_data, with dev_out_strobe[k] high, in the cycle chan_ack[k] is high.
- R5: After each word the start word is rewritten as {bit15, start[14:0]+1}. The address wraps from 0x7FFF to 0x0000 and the direction bit is kept.
- R6: When the address just moved equals end[14:0], chan_done[k] pulses for one cycle, in the same cycle as chan_ack[k].
- R7: After completion, requests on that channel are ignored until a snooped processor write (cpu_wr) hits address 16+2k. The ignored request moves nothing and leaves the start word unchanged.
- R8: Among simultaneous eligible requests, the lowest-numbered channel is served first.
- R9: Each grant moves exactly one word. Arbitration is repeated after every word, so a newly raised lower-numbered request overtakes a channel that keeps requesting.
- R10: From the clock edge that samples a request in idle, chan_ack rises after exactly four edges (sequence: read start, read end, move, write back). At most one chan_ack bit is high, and never in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_req | input | 16 | Per-channel word request, level |
| chan_ack | output | 16 | One-cycle pulse when a channel's word is finished |
| chan_done | output | 16 | One-cycle pulse when a channel reaches its end address |
| dev_in_data | input | 256 | Per-channel device data to memory, channel k in bits 16k+15..16k |
| dev_out_data | output | 16 | Memory data for the output channel being served |
| dev_out_strobe | output | 16 | Per-channel valid for dev_out_data |
| mem_addr | output | 16 | Memory word address |
| mem_rd | output | 1 | Memory read; data is returned one cycle later |
| mem_wr | output | 1 | Memory write |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after mem_rd |
| cpu_wr | input | 1 | Snoop: processor memory write strobe |
| cpu_wr_addr | input | 16 | Snoop: processor memory write address |

## Verification
The checker watches several properties on every cycle:
- exclusive use of the memory port;
- single, non-back-to-back acknowledges;
- completion only together with an acknowledge;
- strobes only with acknowledges;
- a write-back on every acknowledge;
- no service of a channel whose completion has not yet been cleared by a snooped start-word write.

The bench scenarios show the rest:
- the actual addresses and data moved in each direction;
- the value written back, including the 15-bit wrap;
- the four-edge latency;
- lowest-number-first ordering and re-arbitration after every word.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_START,
        ST_RD_END,
        ST_MOVE,
        ST_WRBACK
    } xfer_state_t;

    // direction bit position inside a start word of width w
    function automatic int dir_bit(input int w);
        return w - 1;
    endfunction

endpackage

// File: rtl/dmc_prio_arb.sv
module dmc_prio_arb #(
    parameter int NCH  = 16,
    localparam int IDXW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0]  req,
    output logic            grant_vld,
    output logic [IDXW-1:0] grant_idx
);

    always_comb begin
        grant_vld = |req;
        grant_idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant_idx = IDXW'(i);
            end
        end
    end

endmodule

// File: rtl/dmc_rearm_decode.sv
module dmc_rearm_decode #(
    parameter int NCH      = 16,
    parameter int AW       = 16,
    parameter int PTR_BASE = 16
) (
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    output logic [NCH-1:0] rearm
);

    for (genvar k = 0; k < NCH; k++) begin : g_match
        localparam logic [AW-1:0] START_ADDR = AW'(PTR_BASE + 2 * k);
        assign rearm[k] = wr_en && (wr_addr == START_ADDR);
    end

endmodule

// File: rtl/dmc_chan_flags.sv
module dmc_chan_flags #(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] set_halt,
    input  logic [NCH-1:0] clr_halt,
    output logic [NCH-1:0] halted
);

    for (genvar k = 0; k < NCH; k++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                halted[k] <= 1'b0;
            end else if (set_halt[k]) begin
                halted[k] <= 1'b1;
            end else if (clr_halt[k]) begin
                halted[k] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dmc_engine.sv
module dmc_engine #(
    parameter int NCH      = 16,
    parameter int DW       = 16,
    parameter int PTR_BASE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    chan_req,
    output logic [NCH-1:0]    chan_ack,
    output logic [NCH-1:0]    chan_done,
    input  logic [NCH*DW-1:0] dev_in_data,
    output logic [DW-1:0]     dev_out_data,
    output logic [NCH-1:0]    dev_out_strobe,
    output logic [DW-1:0]     mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    input  logic              cpu_wr,
    input  logic [DW-1:0]     cpu_wr_addr
);
    import dmc_pkg::*;

    localparam int IDXW  = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int DIRB  = dir_bit(DW);
    localparam int ADDRW = DW - 1;

    xfer_state_t state_q, state_d;

    logic [IDXW-1:0]  cur_ch_q;
    logic [DW-1:0]    start_q;
    logic [DW-1:0]    end_q;
    logic [NCH-1:0]   halted;
    logic [NCH-1:0]   rearm;
    logic [NCH-1:0]   eligible;
    logic             grant_vld;
    logic [IDXW-1:0]  grant_idx;
    logic [DW-1:0]    ptr_addr;
    logic [DW-1:0]    dev_in_sel;
    logic [ADDRW-1:0] next_addr;
    logic             is_input;
    logic             is_last;
    logic [NCH-1:0]   done_vec;

    assign eligible   = chan_req & ~halted;
    assign ptr_addr   = DW'(PTR_BASE) + {{(DW-IDXW-1){1'b0}}, cur_ch_q, 1'b0};
    assign dev_in_sel = dev_in_data[cur_ch_q*DW +: DW];
    assign is_input   = start_q[DIRB];
    assign next_addr  = start_q[ADDRW-1:0] + ADDRW'(1);
    assign is_last    = (start_q[ADDRW-1:0] == end_q[ADDRW-1:0]);

    dmc_prio_arb #(.NCH(NCH)) u_arb (
        .req       (eligible),
        .grant_vld (grant_vld),
        .grant_idx (grant_idx)
    );

    dmc_rearm_decode #(.NCH(NCH), .AW(DW), .PTR_BASE(PTR_BASE)) u_rearm (
        .wr_en   (cpu_wr),
        .wr_addr (cpu_wr_addr),
        .rearm   (rearm)
    );

    dmc_chan_flags #(.NCH(NCH)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_halt (done_vec),
        .clr_halt (rearm),
        .halted   (halted)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (grant_vld) state_d = ST_RD_START;
            ST_RD_START: state_d = ST_RD_END;
            ST_RD_END:   state_d = ST_MOVE;
            ST_MOVE:     state_d = ST_WRBACK;
            ST_WRBACK:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // datapath captures
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_ch_q <= '0;
            start_q  <= '0;
            end_q    <= '0;
        end else begin
            if (state_q == ST_IDLE && grant_vld) begin
                cur_ch_q <= grant_idx;
            end
            if (state_q == ST_RD_END) begin
                start_q <= mem_rdata;
            end
            if (state_q == ST_MOVE) begin
                end_q <= mem_rdata;
            end
        end
    end

    // outputs
    always_comb begin
        mem_addr       = '0;
        mem_rd         = 1'b0;
        mem_wr         = 1'b0;
        mem_wdata      = '0;
        chan_ack       = '0;
        done_vec       = '0;
        dev_out_strobe = '0;
        dev_out_data   = '0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_RD_START: begin
                mem_rd   = 1'b1;
                mem_addr = ptr_addr;
            end
            ST_RD_END: begin
                mem_rd   = 1'b1;
                mem_addr = ptr_addr + DW'(1);
            end
            ST_MOVE: begin
                mem_addr = {1'b0, start_q[ADDRW-1:0]};
                if (is_input) begin
                    mem_wr    = 1'b1;
                    mem_wdata = dev_in_sel;
                end else begin
                    mem_rd = 1'b1;
                end
            end
            ST_WRBACK: begin
                mem_wr             = 1'b1;
                mem_addr           = ptr_addr;
                mem_wdata          = {start_q[DIRB], next_addr};
                chan_ack[cur_ch_q] = 1'b1;
                if (!is_input) begin
                    dev_out_strobe[cur_ch_q] = 1'b1;
                    dev_out_data             = mem_rdata;
                end
                if (is_last) begin
                    done_vec[cur_ch_q] = 1'b1;
                end
            end
            default: begin
            end
        endcase
    end

    assign chan_done = done_vec;

endmodule

// File: rtl/dmc_engine_chk.sv
module dmc_engine_chk #(
    parameter int NCH      = 16,
    parameter int DW       = 16,
    parameter int PTR_BASE = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NCH-1:0]    chan_req,
    input logic [NCH-1:0]    chan_ack,
    input logic [NCH-1:0]    chan_done,
    input logic [DW-1:0]     dev_out_data,
    input logic [NCH-1:0]    dev_out_strobe,
    input logic [DW-1:0]     mem_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              cpu_wr,
    input logic [DW-1:0]     cpu_wr_addr
);

    logic [NCH-1:0] shadow_halt;

    for (genvar k = 0; k < NCH; k++) begin : g_shadow
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow_halt[k] <= 1'b0;
            end else if (chan_done[k]) begin
                shadow_halt[k] <= 1'b1;
            end else if (cpu_wr && cpu_wr_addr == DW'(PTR_BASE + 2 * k)) begin
                shadow_halt[k] <= 1'b0;
            end
        end
    end

    a_r1_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    a_r10_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_ack));

    a_r10_ack_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        (|chan_ack) |=> !(|chan_ack));

    a_r6_done_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_done & ~chan_ack) == '0);

    a_r4_strobe_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_out_strobe & ~chan_ack) == '0);

    a_r5_ack_writes_back: assert property (@(posedge clk) disable iff (!rst_n)
        (|chan_ack) |-> mem_wr);

    a_r7_halted_not_served: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_ack & shadow_halt) == '0);

endmodule

bind dmc_engine dmc_engine_chk #(.NCH(NCH), .DW(DW), .PTR_BASE(PTR_BASE)) u_chk (.*);

// File: tb/dmc_engine_test.sv
module dmc_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 16;
    localparam int DW  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    chan_req = '0;
    logic [NCH-1:0]    chan_ack, chan_done, dev_out_strobe;
    logic [NCH*DW-1:0] dev_in_data = '0;
    logic [DW-1:0]     dev_out_data, mem_addr, mem_wdata;
    logic              mem_rd, mem_wr;
    logic [DW-1:0]     mem_rdata = '0;
    logic              cpu_wr = 1'b0;
    logic [DW-1:0]     cpu_wr_addr = '0;

    logic [DW-1:0] mem [0:1023];

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmc_engine #(.NCH(NCH), .DW(DW), .PTR_BASE(16)) uut (
        .clk(clk), .rst_n(rst_n), .chan_req(chan_req), .chan_ack(chan_ack),
        .chan_done(chan_done), .dev_in_data(dev_in_data),
        .dev_out_data(dev_out_data), .dev_out_strobe(dev_out_strobe),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .cpu_wr(cpu_wr), .cpu_wr_addr(cpu_wr_addr)
    );

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic cpu_store(input int addr, input logic [DW-1:0] val);
        @(negedge clk);
        mem[addr] = val;
        cpu_wr = 1'b1;
        cpu_wr_addr = DW'(addr);
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    // waits for any ack; returns cycles, sampled ack/done/strobe/data
    task automatic wait_ack(output int n, output logic [NCH-1:0] a,
                            output logic [NCH-1:0] d, output logic [NCH-1:0] s,
                            output logic [DW-1:0] q);
        n = -1; a = '0; d = '0; s = '0; q = '0;
        for (int i = 1; i <= 60; i++) begin
            @(negedge clk);
            if (|chan_ack) begin
                n = i; a = chan_ack; d = chan_done; s = dev_out_strobe; q = dev_out_data;
                return;
            end
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(chan_ack == '0 && chan_done == '0 && dev_out_strobe == '0,
              "R1 outputs idle in reset", int'(chan_ack), 0);
        check(!mem_rd && !mem_wr, "R1 memory idle in reset", int'({mem_rd, mem_wr}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!mem_rd && !mem_wr && chan_ack == '0, "R1 idle after reset",
              int'({mem_rd, mem_wr}), 0);
    endtask

    task automatic t_input();
        int n; logic [NCH-1:0] a, d, s; logic [DW-1:0] q;
        cpu_store(22, 16'h8000 | 16'd200);
        cpu_store(23, 16'd202);
        for (int w = 0; w < 3; w++) begin
            dev_in_data[3*DW +: DW] = 16'hA500 + DW'(w);
            chan_req[3] = 1'b1;
            wait_ack(n, a, d, s, q);
            chan_req[3] = 1'b0;
            if (w == 0) check(n == 4, "R10 ack four edges after request", n, 4);
            check(a == 16'h0008, "R3 ack on channel 3", int'(a), 16'h0008);
            check(s == '0, "R3 no strobe for input channel", int'(s), 0);
            check(d == ((w == 2) ? 16'h0008 : 16'h0000), "R6 done only on last word",
                  int'(d), (w == 2) ? 8 : 0);
            @(negedge clk);
            check(mem[200 + w] == 16'hA500 + DW'(w), "R3 device word in memory",
                  int'(mem[200 + w]), int'(16'hA500 + w));
            check(mem[22] == (16'h8000 | DW'(201 + w)), "R2 R5 start word advanced",
                  int'(mem[22]), int'(16'h8000 | (201 + w)));
        end
    endtask

    task automatic t_output();
        int n; logic [NCH-1:0] a, d, s; logic [DW-1:0] q;
        mem[300] = 16'h1234;
        cpu_store(16, 16'd300);
        cpu_store(17, 16'd300);
        chan_req[0] = 1'b1;
        wait_ack(n, a, d, s, q);
        chan_req[0] = 1'b0;
        check(s == 16'h0001, "R4 strobe on channel 0", int'(s), 1);
        check(q == 16'h1234, "R4 memory word delivered", int'(q), 16'h1234);
        check(d == 16'h0001, "R6 single-word channel completes", int'(d), 1);
        @(negedge clk);
        check(mem[16] == 16'd301, "R5 output start word advanced", int'(mem[16]), 301);
    endtask

    task automatic t_halt();
        int n; logic [NCH-1:0] a, d, s; logic [DW-1:0] q;
        chan_req[0] = 1'b1;
        wait_ack(n, a, d, s, q);
        check(n == -1, "R7 completed channel ignored", n, -1);
        check(mem[16] == 16'd301, "R7 start word untouched", int'(mem[16]), 301);
        mem[310] = 16'h5678;
        cpu_store(17, 16'd310);
        cpu_store(16, 16'd310);
        wait_ack(n, a, d, s, q);
        chan_req[0] = 1'b0;
        check(a == 16'h0001 && q == 16'h5678, "R7 rearmed channel served", int'(q), 16'h5678);
    endtask

    task automatic t_priority();
        int n; logic [NCH-1:0] a, d, s; logic [DW-1:0] q;
        cpu_store(20, 16'd400); cpu_store(21, 16'd420);
        cpu_store(34, 16'd500); cpu_store(35, 16'd520);
        cpu_store(18, 16'd600); cpu_store(19, 16'd620);
        cpu_store(24, 16'd700); cpu_store(25, 16'd720);
        @(negedge clk);
        chan_req[2] = 1'b1;
        chan_req[9] = 1'b1;
        wait_ack(n, a, d, s, q);
        check(a == 16'h0004, "R8 lowest channel first", int'(a), 4);
        chan_req[2] = 1'b0;
        chan_req[1] = 1'b1;
        wait_ack(n, a, d, s, q);
        check(a == 16'h0002, "R8 channel 1 beats channel 9", int'(a), 2);
        chan_req[1] = 1'b0;
        wait_ack(n, a, d, s, q);
        check(a == 16'h0200, "R9 channel 9 served", int'(a), 16'h0200);
        chan_req[4] = 1'b1;
        wait_ack(n, a, d, s, q);
        check(a == 16'h0010, "R9 rearbitration per word", int'(a), 16'h0010);
        chan_req[4] = 1'b0;
        wait_ack(n, a, d, s, q);
        chan_req[9] = 1'b0;
        check(a == 16'h0200, "R9 channel 9 resumes", int'(a), 16'h0200);
        @(negedge clk);
        check(mem[34] == 16'd502, "R9 one word per grant", int'(mem[34]), 502);
    endtask

    task automatic t_wrap();
        int n; logic [NCH-1:0] a, d, s; logic [DW-1:0] q;
        cpu_store(46, 16'h7FFF);
        cpu_store(47, 16'h0005);
        chan_req[15] = 1'b1;
        wait_ack(n, a, d, s, q);
        chan_req[15] = 1'b0;
        check(d == '0, "R6 no done before end", int'(d), 0);
        @(negedge clk);
        check(mem[46] == 16'h0000, "R5 address wraps", int'(mem[46]), 0);
        cpu_store(46, 16'hFFFF);
        chan_req[15] = 1'b1;
        wait_ack(n, a, d, s, q);
        chan_req[15] = 1'b0;
        @(negedge clk);
        check(mem[46] == 16'h8000, "R5 wrap keeps direction", int'(mem[46]), 16'h8000);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        t_reset();
        t_input();
        t_output();
        t_halt();
        t_priority();
        t_wrap();
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule